// File: doc/BRIEF.md
# Legacy Interrupt-Map Autodetect FSM

This block watches configuration-space write strobes on the host side of a PCI bridge and decides whether the software running on the system expects an old, wrong slot-to-interrupt wiring. When software programs the interrupt-line register of a device, the value it writes shows which wiring it assumes. The block compares that value against the wrong patterns that are known. It then records whether the software is legacy (broken), correct (forced OK), or not yet known.

The result is a two-bit mapping mode that the interrupt router reads. The mode starts at a strap-selected default on reset. It may leave the undecided state once, and only on a write that tells the two wirings apart. After that it holds until the next reset. A board-variant strap turns detection off for the alternate board type.

Top module: `irqmap_autodetect`

## Requirements
- R1: The mode output uses the encodings 0 = undecided, 1 = legacy-broken and 2 = forced-correct. While reset is low, the output follows the reset-default input, and a default of 3 loads as 0.
- R2: A write is qualifying only when all of these hold: the write strobe is high, the variant strap is 0, address bits [7:0] equal 0x3C, and the mode is 0. Any other write leaves the mode unchanged.
- R3: Once the mode is 1 or 2, no write changes it until reset. This holds also when the mode came from the reset default.
- R4: The slot is address bits [15:11], taken modulo 4, which is address bits [12:11]. The function bits [10:8] and the address bits above bit 15 do not affect the slot.
- R5: A qualifying write of 27 gives mode 1, except in slot 2 (mod 4). There the mode stays 0 and later writes are still classified.
- R6: A qualifying write of 27 plus the slot gives mode 1.
- R7: A qualifying write of 91 plus the slot gives mode 1.
- R8: A qualifying write of any other value gives mode 2. Only write-data bits [7:0] are compared, and the bits above them are ignored.
- R9: The mode changes at the rising clock edge that samples the qualifying write, and not before that edge.
- R10: When the variant strap is 1, a write to offset 0x3C has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe, one per cycle |
| cfg_addr | input | 24 | Configuration address: device/function in bits [15:8], register offset in bits [7:0] |
| cfg_wdata | input | 32 | Configuration write data |
| alt_board | input | 1 | Variant strap; 1 turns detection off |
| reset_mode | input | 2 | Mode loaded while reset is asserted |
| map_mode | output | 2 | Current interrupt mapping mode |

## Verification
Writes of 27 go to slots 0, 3 and 2, and to slot 6, which is slot 2 modulo 4. These tell the all-slots legacy pattern apart from the ambiguous slot-2 case, and a follow-up write proves that detection is still live afterwards. The rotated pattern and the pattern offset by 64 are each tried in two slots. The correct-wiring value 29 in slot 0 and the value 92 in slot 0 are tried too: each of those matches a bad pattern only in another slot, so both must give the forced-correct verdict. Wrong offsets, a dropped strobe, the variant strap, junk in the upper data bits and writes after a decision are used to show which stimuli are ignored. Each strap-selected reset default is also checked, including the reserved code 3.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
    typedef enum logic [1:0] {
        MAP_ASSUME_OK = 2'd0,
        MAP_BROKEN    = 2'd1,
        MAP_FORCE_OK  = 2'd2
    } map_mode_e;

    typedef struct packed {
        map_mode_e mode;
    } mode_state_t;
endpackage

// File: rtl/irqmap_qualify.sv
module irqmap_qualify #(
    parameter int          ADDR_W   = 24,
    parameter int          SLOT_W   = 2,
    parameter logic [7:0]  LINE_OFS = 8'h3C
) (
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              alt_board,
    output logic              line_hit,
    output logic [SLOT_W-1:0] slot
);
    localparam int DEVFN_LSB = 8;
    localparam int SLOT_LSB  = DEVFN_LSB + 3;

    // slot field of devfn, reduced modulo 2**SLOT_W by keeping low bits
    assign slot     = cfg_addr[SLOT_LSB +: SLOT_W];
    assign line_hit = cfg_wr && !alt_board && (cfg_addr[7:0] == LINE_OFS);
endmodule

// File: rtl/irqmap_classify.sv
module irqmap_classify
    import irqmap_pkg::*;
#(
    parameter int SLOT_W     = 2,
    parameter int BASE_IRQ   = 27,
    parameter int HIGH_OFS   = 64,
    parameter int AMBIG_SLOT = 2
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [7:0]        value,
    output map_mode_e         verdict
);
    localparam logic [7:0]        BASE_V  = 8'(BASE_IRQ);
    localparam logic [7:0]        HIGH_V  = 8'(HIGH_OFS);
    localparam logic [SLOT_W-1:0] AMBIG_V = SLOT_W'(AMBIG_SLOT);

    logic [7:0] rotated;
    logic [7:0] lifted;

    always_comb begin
        rotated = BASE_V + 8'(slot);
        lifted  = rotated + HIGH_V;
        if (value == BASE_V) begin
            verdict = (slot == AMBIG_V) ? MAP_ASSUME_OK : MAP_BROKEN;
        end else if (value == rotated || value == lifted) begin
            verdict = MAP_BROKEN;
        end else begin
            verdict = MAP_FORCE_OK;
        end
    end
endmodule

// File: rtl/irqmap_mode_reg.sv
module irqmap_mode_reg
    import irqmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_hit,
    input  map_mode_e  verdict,
    input  logic [1:0] reset_mode,
    output map_mode_e  mode
);
    mode_state_t state_d, state_q;
    map_mode_e   reset_val;

    always_comb begin
        reset_val = (reset_mode == 2'd3) ? MAP_ASSUME_OK : map_mode_e'(reset_mode);
        state_d   = state_q;
        if (line_hit && state_q.mode == MAP_ASSUME_OK) begin
            state_d.mode = verdict;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode <= reset_val;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode = state_q.mode;

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode != MAP_ASSUME_OK) |=> $stable(state_q.mode));

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.mode != map_mode_e'(2'd3));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_hit |=> $stable(state_q.mode));
endmodule

// File: rtl/irqmap_autodetect.sv
module irqmap_autodetect
    import irqmap_pkg::*;
#(
    parameter int         ADDR_W   = 24,
    parameter int         DATA_W   = 32,
    parameter int         SLOT_W   = 2,
    parameter int         BASE_IRQ = 27,
    parameter int         HIGH_OFS = 64,
    parameter logic [7:0] LINE_OFS = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              alt_board,
    input  logic [1:0]        reset_mode,
    output logic [1:0]        map_mode
);
    logic              line_hit;
    logic [SLOT_W-1:0] slot;
    map_mode_e         verdict;
    map_mode_e         mode;

    irqmap_qualify #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .LINE_OFS(LINE_OFS)) u_qualify (
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .alt_board (alt_board),
        .line_hit  (line_hit),
        .slot      (slot)
    );

    irqmap_classify #(.SLOT_W(SLOT_W), .BASE_IRQ(BASE_IRQ), .HIGH_OFS(HIGH_OFS)) u_classify (
        .slot    (slot),
        .value   (cfg_wdata[7:0]),
        .verdict (verdict)
    );

    irqmap_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_hit   (line_hit),
        .verdict    (verdict),
        .reset_mode (reset_mode),
        .mode       (mode)
    );

    assign map_mode = mode;

    assert_ambig_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !alt_board && cfg_addr[7:0] == LINE_OFS && cfg_addr[12:11] == 2'd2
         && cfg_wdata[7:0] == 8'(BASE_IRQ) && map_mode == 2'd0) |=> map_mode == 2'd0);

    assert_strap_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alt_board |=> $stable(map_mode));

    assert_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hit && map_mode == 2'd0) |=> map_mode == $past(verdict));
endmodule

// File: tb/test_irqmap_autodetect.sv
`timescale 1ns/1ps
module test_irqmap_autodetect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        alt_board = 1'b0;
    logic [1:0]  reset_mode = 2'd0;
    logic [1:0]  map_mode;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irqmap_autodetect i_irqmap_autodetect (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .alt_board(alt_board), .reset_mode(reset_mode),
        .map_mode(map_mode)
    );

    function automatic logic [23:0] mk_addr(input int slot, input int fn, input logic [7:0] ofs);
        return {8'h00, 5'(slot), 3'(fn), ofs};
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        total++;
        if (map_mode !== exp) begin
            bad++;
            $display("FAIL %s: map_mode=%0d expected=%0d", tag, map_mode, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] dflt);
        @(negedge clk);
        rst_n = 1'b0;
        reset_mode = dflt;
        cfg_wr = 1'b0;
        alt_board = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        cfg_wdata = d;
        cfg_wr = 1'b1;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
    endtask

    task automatic t_reset_defaults;
        do_reset(2'd0); check("R1 default 0", 2'd0);
        do_reset(2'd1); check("R1 default 1", 2'd1);
        do_reset(2'd2); check("R1 default 2", 2'd2);
        do_reset(2'd3); check("R1 default 3 loads 0", 2'd0);
    endtask

    task automatic t_base_value;
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'd27); check("R5 slot0 27", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(11, 5, 8'h3C), 32'd27); check("R5 R4 slot11 27", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(2, 0, 8'h3C), 32'd27); check("R5 slot2 27 stays", 2'd0);
        cfg_write(mk_addr(2, 0, 8'h3C), 32'd29); check("R5 R6 slot2 then 29", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(6, 0, 8'h3C), 32'd27); check("R5 R4 slot6 27 stays", 2'd0);
    endtask

    task automatic t_rotated;
        do_reset(2'd0); cfg_write(mk_addr(1, 0, 8'h3C), 32'd28); check("R6 slot1 28", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(3, 0, 8'h3C), 32'd30); check("R6 slot3 30", 2'd1);
    endtask

    task automatic t_lifted;
        do_reset(2'd0); cfg_write(mk_addr(1, 0, 8'h3C), 32'd92); check("R7 slot1 92", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(2, 0, 8'h3C), 32'd93); check("R7 slot2 93", 2'd1);
    endtask

    task automatic t_other;
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'd29); check("R8 slot0 29", 2'd2);
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'd92); check("R8 slot0 92", 2'd2);
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'hABCD_011B); check("R8 upper bits ignored", 2'd1);
    endtask

    task automatic t_unqualified;
        do_reset(2'd0);
        cfg_write(mk_addr(0, 0, 8'h3D), 32'd50); check("R2 wrong offset", 2'd0);
        @(negedge clk); cfg_addr = mk_addr(0, 0, 8'h3C); cfg_wdata = 32'd50; cfg_wr = 1'b0;
        @(negedge clk); check("R2 no strobe", 2'd0);
        @(negedge clk); alt_board = 1'b1;
        cfg_write(mk_addr(0, 0, 8'h3C), 32'd50); check("R10 strap off", 2'd0);
        @(negedge clk); alt_board = 1'b0;
        cfg_write(mk_addr(0, 0, 8'h3C), 32'd27); check("R2 still live", 2'd1);
    endtask

    task automatic t_sticky;
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'd27);
        cfg_write(mk_addr(0, 0, 8'h3C), 32'd50); check("R3 broken holds", 2'd1);
        do_reset(2'd0); cfg_write(mk_addr(0, 0, 8'h3C), 32'd50);
        cfg_write(mk_addr(0, 0, 8'h3C), 32'd27); check("R3 forced holds", 2'd2);
        do_reset(2'd1); cfg_write(mk_addr(0, 0, 8'h3C), 32'd50); check("R3 reset default holds", 2'd1);
    endtask

    task automatic t_timing;
        do_reset(2'd0);
        @(negedge clk);
        cfg_addr = mk_addr(0, 0, 8'h3C); cfg_wdata = 32'd27; cfg_wr = 1'b1;
        #1 check("R9 before edge", 2'd0);
        @(posedge clk);
        #1 cfg_wr = 1'b0;
        check("R9 after edge", 2'd1);
    endtask

    initial begin
        t_reset_defaults();
        t_base_value();
        t_rotated();
        t_lifted();
        t_other();
        t_unqualified();
        t_sticky();
        t_timing();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule